// File: doc/BRIEF.md
# Endpoint-Zero Control Transfer Stage Controller

This block follows a device-side USB control transfer on endpoint zero from the SETUP packet to the end of the status stage. A packet layer passes it decoded events. These are a SETUP token that arrives together with its 8-byte request, and IN and OUT tokens. The block keeps the request as four 16-bit fields and works out from them whether the transfer is a control read, a control write or a no-data transfer. It then moves through the stages and picks the handshake or packet for each token. It also supplies the DATA0/DATA1 PID.

Software sees a request-valid flag, a response setting (NAK, STALL or BUF) and a control-complete bit. A new SETUP always wins over a transfer in progress. It raises the valid flag, forces the response to NAK and clears the complete bit. Until software writes the valid flag to 0, the block ignores any attempt to select BUF or to end the transfer. A token that does not fit the expected next stage halts the transfer with STALL and raises a one-cycle sequence-error pulse. Every stage change raises a one-cycle interrupt pulse.

Top module: `ep0_stage_ctrl`

## Requirements
- R1: A SETUP event (`setup_pkt_i`) is answered with ACK (`hs_o`=1, PID DATA0) in the next cycle, whatever the stage or response setting, including the halted state.
- R2: A SETUP event sets `req_valid_o`=1, `rsp_o`=NAK, `ccpl_o`=0 and `stage_o`=SETUP. A pulse on `sw_clr_valid_i` clears `req_valid_o`. Stage codes are: 0 IDLE, 1 SETUP, 2 DATA_IN, 3 DATA_OUT, 4 STATUS_IN, 5 STATUS_OUT, 6 HALT.
- R3: The 64-bit request is stored little-endian: `req_o`=bits 15:0 (the low byte is the request type), `value_o`=31:16, `index_o`=47:32, `length_o`=63:48.
- R4: While `req_valid_o`=1, a software write of BUF (`sw_rsp_i`=2) leaves `rsp_o` unchanged, and `sw_ccpl_set_i` leaves `ccpl_o` at 0.
- R5: `xfer_type_o` is 0 (no-data) when the length is zero. Otherwise it is 1 (read) when bit 7 of the request-type byte is 1, and 2 (write) when that bit is 0.
- R6: From SETUP, the first token moves the stage as follows. A read goes to DATA_IN on IN. A write goes to DATA_OUT on OUT. A no-data transfer goes to STATUS_IN on IN. After that, a token opposite to the data direction enters the matching status stage.
- R7: A token that does not fit the stage sends the stage to HALT. It answers STALL, sets `rsp_o`=STALL and pulses `seq_err_o` for one cycle. Mismatches are: the wrong direction first after SETUP, or the wrong direction in a status stage.
- R8: A data-stage token gets a reply set by `rsp_o` (encoding 0 NAK, 1 STALL, 2 BUF). NAK gives `hs_o`=2 and STALL gives 3. BUF gives a data packet (`hs_o`=4) for IN and ACK (`hs_o`=1) for OUT. A token in IDLE gets NAK. A token in HALT gets STALL.
- R9: The first data-stage packet after SETUP uses DATA1 (`pid_o`=1), and the PID alternates on every data packet sent or accepted. Status-stage traffic always uses DATA1.
- R10: In a status stage with `ccpl_o`=1, an IN token is answered with a zero-length packet (`hs_o`=5) and an OUT token with ACK, and the stage returns to IDLE. With `ccpl_o`=0 the status token gets NAK and the stage remains.
- R11: A SETUP in any stage, including mid-data, reloads all fields and restarts at the SETUP stage. It also replaces a STALL response with NAK.
- R12: `stage_irq_o` is high for exactly one cycle after each cycle in which `stage_o` changed, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_pkt_i | input | 1 | SETUP token with valid 8-byte request, one-cycle pulse |
| setup_bytes_i | input | 64 | Request bytes, byte 0 in bits 7:0 |
| in_tok_i | input | 1 | IN token on endpoint zero |
| out_tok_i | input | 1 | OUT token (with its data packet) on endpoint zero |
| sw_clr_valid_i | input | 1 | Software write of 0 to the request-valid flag |
| sw_rsp_wr_i | input | 1 | Software write of the response setting |
| sw_rsp_i | input | 2 | Response value: 0 NAK, 1 STALL, 2 BUF |
| sw_ccpl_set_i | input | 1 | Software sets the control-complete bit |
| req_valid_o | output | 1 | New request pending software acknowledgement |
| ccpl_o | output | 1 | Control-complete bit |
| rsp_o | output | 2 | Current response setting |
| hs_o | output | 3 | Reply for the last event: 0 none, 1 ACK, 2 NAK, 3 STALL, 4 data, 5 zero-length packet |
| pid_o | output | 1 | Data PID for that reply: 0 DATA0, 1 DATA1 |
| stage_o | output | 3 | Current stage code |
| stage_irq_o | output | 1 | Stage-change pulse |
| seq_err_o | output | 1 | Sequence-error pulse |
| xfer_type_o | output | 2 | 0 no-data, 1 read, 2 write |
| req_o | output | 16 | Request type and request code |
| value_o | output | 16 | Value field |
| index_o | output | 16 | Index field |
| length_o | output | 16 | Length field |

## Verification
The assertions assume the following about the inputs:
- At most one of `setup_pkt_i`, `in_tok_i` and `out_tok_i` is high in any cycle.
- Every event is a single-cycle pulse sampled at a clock edge.
- `sw_rsp_i` never carries the unused code 3.

The stimulus keeps to these limits. Each table row drives exactly one event or one software write per cycle, and returns every strobe to zero at the next step. The request images are chosen so that every transfer type appears, including a zero-length request.

// File: rtl/ep0_pkg.sv
// Shared encodings for the endpoint-zero stage controller.
// Assumes: codes below are visible at the top ports and must stay fixed.
package ep0_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_DIN   = 3'd2,
        ST_DOUT  = 3'd3,
        ST_SIN   = 3'd4,
        ST_SOUT  = 3'd5,
        ST_HALT  = 3'd6
    } stage_e;

    typedef enum logic [1:0] {
        RSP_NAK   = 2'd0,
        RSP_STALL = 2'd1,
        RSP_BUF   = 2'd2
    } rsp_e;

    typedef enum logic [2:0] {
        HS_NONE  = 3'd0,
        HS_ACK   = 3'd1,
        HS_NAK   = 3'd2,
        HS_STALL = 3'd3,
        HS_DATA  = 3'd4,
        HS_ZLP   = 3'd5
    } hs_e;

    typedef enum logic [1:0] {
        XT_NODATA = 2'd0,
        XT_READ   = 2'd1,
        XT_WRITE  = 2'd2
    } xtype_e;

    typedef enum logic [2:0] {
        TK_NONE   = 3'd0,
        TK_DATA   = 3'd1,
        TK_STATUS = 3'd2,
        TK_ERR    = 3'd3,
        TK_OTHER  = 3'd4
    } tok_e;
endpackage

// File: rtl/ep0_req_capture.sv
// Stores the request image carried with a SETUP event as NFIELD fields
// and classifies the transfer from the direction bit and the last field.
// Assumes: field 0 holds the request-type byte in its low byte; the last
// field is the length.
module ep0_req_capture
    import ep0_pkg::*;
#(
    parameter int FIELD_W = 16,
    parameter int NFIELD  = 4,
    parameter int DIR_BIT = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      setup_pkt,
    input  logic [FIELD_W*NFIELD-1:0] setup_bytes,
    output logic [FIELD_W*NFIELD-1:0] fields,
    output xtype_e                    xtype
);
    localparam int LEN_LSB = FIELD_W * (NFIELD - 1);

    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        // Load one field when a SETUP arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fields[g*FIELD_W +: FIELD_W] <= '0;
            else if (setup_pkt)
                fields[g*FIELD_W +: FIELD_W] <= setup_bytes[g*FIELD_W +: FIELD_W];
        end
    end

    // Classify from the stored direction bit and length field.
    always_comb begin
        if (fields[LEN_LSB +: FIELD_W] == '0)
            xtype = XT_NODATA;
        else if (fields[DIR_BIT])
            xtype = XT_READ;
        else
            xtype = XT_WRITE;
    end
endmodule

// File: rtl/ep0_stage_fsm.sv
// Stage machine: sorts each token into data, status, error or other
// and advances the stage; pulses on stage change and on sequence error.
// Assumes: at most one of setup_pkt, in_tok, out_tok per cycle.
module ep0_stage_fsm
    import ep0_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   setup_pkt,
    input  logic   in_tok,
    input  logic   out_tok,
    input  xtype_e xtype,
    input  logic   done_ok,
    output stage_e stage,
    output tok_e   tok_kind,
    output logic   stage_irq,
    output logic   seq_err
);
    stage_e stage_nx;

    // Token classification and next stage.
    always_comb begin
        tok_kind = TK_NONE;
        stage_nx = stage;
        if (setup_pkt) begin
            stage_nx = ST_SETUP;
        end else if (in_tok || out_tok) begin
            unique case (stage)
                ST_SETUP: begin
                    if (xtype == XT_READ && in_tok) begin
                        tok_kind = TK_DATA;   stage_nx = ST_DIN;
                    end else if (xtype == XT_WRITE && out_tok) begin
                        tok_kind = TK_DATA;   stage_nx = ST_DOUT;
                    end else if (xtype == XT_NODATA && in_tok) begin
                        tok_kind = TK_STATUS; stage_nx = ST_SIN;
                    end else begin
                        tok_kind = TK_ERR;
                    end
                end
                ST_DIN: begin
                    if (in_tok) tok_kind = TK_DATA;
                    else begin tok_kind = TK_STATUS; stage_nx = ST_SOUT; end
                end
                ST_DOUT: begin
                    if (out_tok) tok_kind = TK_DATA;
                    else begin tok_kind = TK_STATUS; stage_nx = ST_SIN; end
                end
                ST_SIN:  tok_kind = in_tok  ? TK_STATUS : TK_ERR;
                ST_SOUT: tok_kind = out_tok ? TK_STATUS : TK_ERR;
                default: tok_kind = TK_OTHER;
            endcase
            if (tok_kind == TK_ERR)
                stage_nx = ST_HALT;
            else if (tok_kind == TK_STATUS && done_ok)
                stage_nx = ST_IDLE;
        end
    end

    // Stage register with change and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage     <= ST_IDLE;
            stage_irq <= 1'b0;
            seq_err   <= 1'b0;
        end else begin
            stage     <= stage_nx;
            stage_irq <= (stage_nx != stage);
            seq_err   <= (tok_kind == TK_ERR);
        end
    end
endmodule

// File: rtl/ep0_resp_ctrl.sv
// Software-visible flags, response setting, data toggle and the reply
// chosen for each event.
// Assumes: tok_kind comes from the stage machine in the same cycle.
module ep0_resp_ctrl
    import ep0_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       setup_pkt,
    input  logic       in_tok,
    input  tok_e       tok_kind,
    input  logic       sw_clr_valid,
    input  logic       sw_rsp_wr,
    input  logic [1:0] sw_rsp,
    input  logic       sw_ccpl_set,
    output logic       req_valid,
    output logic       ccpl,
    output rsp_e       rsp,
    output hs_e        hs,
    output logic       pid,
    output logic       done_ok
);
    logic toggle;
    logic rsp_wr_ok;

    assign done_ok   = ccpl && !req_valid;
    assign rsp_wr_ok = sw_rsp_wr && (sw_rsp != 2'd3) &&
                       !(req_valid && sw_rsp == RSP_BUF);

    // Request-valid flag and control-complete bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            ccpl      <= 1'b0;
        end else if (setup_pkt) begin
            req_valid <= 1'b1;
            ccpl      <= 1'b0;
        end else begin
            if (sw_clr_valid) req_valid <= 1'b0;
            if (sw_ccpl_set && !req_valid) ccpl <= 1'b1;
        end
    end

    // Response setting: SETUP forces NAK, error forces STALL, else software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp <= RSP_NAK;
        else if (setup_pkt)
            rsp <= RSP_NAK;
        else if (tok_kind == TK_ERR)
            rsp <= RSP_STALL;
        else if (rsp_wr_ok)
            rsp <= rsp_e'(sw_rsp);
    end

    // Reply, PID and toggle for each event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs     <= HS_NONE;
            pid    <= 1'b0;
            toggle <= 1'b1;
        end else begin
            hs <= HS_NONE;
            if (setup_pkt) begin
                hs     <= HS_ACK;
                pid    <= 1'b0;
                toggle <= 1'b1;
            end else begin
                unique case (tok_kind)
                    TK_DATA: begin
                        pid <= toggle;
                        if (rsp == RSP_BUF) begin
                            hs     <= in_tok ? HS_DATA : HS_ACK;
                            toggle <= !toggle;
                        end else begin
                            hs <= (rsp == RSP_STALL) ? HS_STALL : HS_NAK;
                        end
                    end
                    TK_STATUS: begin
                        pid    <= 1'b1;
                        toggle <= 1'b1;
                        if (done_ok)
                            hs <= in_tok ? HS_ZLP : HS_ACK;
                        else
                            hs <= (rsp == RSP_STALL) ? HS_STALL : HS_NAK;
                    end
                    TK_ERR: begin
                        pid <= toggle;
                        hs  <= HS_STALL;
                    end
                    TK_OTHER: begin
                        pid <= toggle;
                        hs  <= (rsp == RSP_STALL) ? HS_STALL : HS_NAK;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ep0_stage_ctrl.sv
// Top: endpoint-zero control-transfer stage controller. Ties the request
// store, the stage machine and the response logic to the ports.
// Assumes: events are one-cycle pulses, at most one per cycle.
module ep0_stage_ctrl
    import ep0_pkg::*;
#(
    parameter int FIELD_W = 16,
    parameter int NFIELD  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      setup_pkt_i,
    input  logic [FIELD_W*NFIELD-1:0] setup_bytes_i,
    input  logic                      in_tok_i,
    input  logic                      out_tok_i,
    input  logic                      sw_clr_valid_i,
    input  logic                      sw_rsp_wr_i,
    input  logic [1:0]                sw_rsp_i,
    input  logic                      sw_ccpl_set_i,
    output logic                      req_valid_o,
    output logic                      ccpl_o,
    output logic [1:0]                rsp_o,
    output logic [2:0]                hs_o,
    output logic                      pid_o,
    output logic [2:0]                stage_o,
    output logic                      stage_irq_o,
    output logic                      seq_err_o,
    output logic [1:0]                xfer_type_o,
    output logic [FIELD_W-1:0]        req_o,
    output logic [FIELD_W-1:0]        value_o,
    output logic [FIELD_W-1:0]        index_o,
    output logic [FIELD_W-1:0]        length_o
);
    logic [FIELD_W*NFIELD-1:0] fields;
    xtype_e xtype;
    stage_e stage;
    tok_e   tok_kind;
    rsp_e   rsp;
    hs_e    hs;
    logic   done_ok;

    ep0_req_capture #(.FIELD_W(FIELD_W), .NFIELD(NFIELD)) u_req (
        .clk(clk), .rst_n(rst_n), .setup_pkt(setup_pkt_i),
        .setup_bytes(setup_bytes_i), .fields(fields), .xtype(xtype)
    );

    ep0_stage_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .setup_pkt(setup_pkt_i),
        .in_tok(in_tok_i), .out_tok(out_tok_i), .xtype(xtype),
        .done_ok(done_ok), .stage(stage), .tok_kind(tok_kind),
        .stage_irq(stage_irq_o), .seq_err(seq_err_o)
    );

    ep0_resp_ctrl u_rsp (
        .clk(clk), .rst_n(rst_n), .setup_pkt(setup_pkt_i),
        .in_tok(in_tok_i), .tok_kind(tok_kind),
        .sw_clr_valid(sw_clr_valid_i), .sw_rsp_wr(sw_rsp_wr_i),
        .sw_rsp(sw_rsp_i), .sw_ccpl_set(sw_ccpl_set_i),
        .req_valid(req_valid_o), .ccpl(ccpl_o), .rsp(rsp), .hs(hs),
        .pid(pid_o), .done_ok(done_ok)
    );

    assign stage_o     = stage;
    assign rsp_o       = rsp;
    assign hs_o        = hs;
    assign xfer_type_o = xtype;
    assign req_o       = fields[0*FIELD_W +: FIELD_W];
    assign value_o     = fields[1*FIELD_W +: FIELD_W];
    assign index_o     = fields[2*FIELD_W +: FIELD_W];
    assign length_o    = fields[(NFIELD-1)*FIELD_W +: FIELD_W];
endmodule

// File: rtl/ep0_stage_chk.sv
// Property checker bound to ep0_stage_ctrl; observes ports only.
// Assumes: the input rules stated in the brief's verification section.
module ep0_stage_chk #(
    parameter int FIELD_W = 16,
    parameter int NFIELD  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      setup_pkt_i,
    input logic [FIELD_W*NFIELD-1:0] setup_bytes_i,
    input logic                      in_tok_i,
    input logic                      out_tok_i,
    input logic                      sw_clr_valid_i,
    input logic                      sw_rsp_wr_i,
    input logic [1:0]                sw_rsp_i,
    input logic                      sw_ccpl_set_i,
    input logic                      req_valid_o,
    input logic                      ccpl_o,
    input logic [1:0]                rsp_o,
    input logic [2:0]                hs_o,
    input logic                      pid_o,
    input logic [2:0]                stage_o,
    input logic                      stage_irq_o,
    input logic                      seq_err_o,
    input logic [1:0]                xfer_type_o,
    input logic [FIELD_W-1:0]        req_o,
    input logic [FIELD_W-1:0]        value_o,
    input logic [FIELD_W-1:0]        index_o,
    input logic [FIELD_W-1:0]        length_o
);
    assert_setup_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        setup_pkt_i |=> (hs_o == 3'd1 && !pid_o));

    assert_setup_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        setup_pkt_i |=> (req_valid_o && !ccpl_o && rsp_o == 2'd0 && stage_o == 3'd1));

    assert_buf_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !setup_pkt_i && sw_rsp_wr_i && sw_rsp_i == 2'd2)
            |=> (rsp_o == $past(rsp_o)));

    assert_ccpl_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !ccpl_o && !setup_pkt_i) |=> !ccpl_o);

    assert_seq_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err_o |-> (stage_o == 3'd6 && hs_o == 3'd3 && rsp_o == 2'd1));

    assert_data_needs_buf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_o == 3'd4) |-> ($past(rsp_o) == 2'd2));

    assert_zlp_data1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_o == 3'd5) |-> (pid_o && stage_o == 3'd0));

    assert_irq_on_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stage_irq_o == !$stable(stage_o));
endmodule

bind ep0_stage_ctrl ep0_stage_chk #(.FIELD_W(FIELD_W), .NFIELD(NFIELD)) u_chk (.*);

// File: tb/sim_ep0_stage_ctrl.sv
module sim_ep0_stage_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_pkt_i = 0, in_tok_i = 0, out_tok_i = 0;
    logic [63:0] setup_bytes_i = '0;
    logic        sw_clr_valid_i = 0, sw_rsp_wr_i = 0, sw_ccpl_set_i = 0;
    logic [1:0]  sw_rsp_i = '0;
    logic        req_valid_o, ccpl_o, pid_o, stage_irq_o, seq_err_o;
    logic [1:0]  rsp_o, xfer_type_o;
    logic [2:0]  hs_o, stage_o;
    logic [15:0] req_o, value_o, index_o, length_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = !clk;

    ep0_stage_ctrl u0 (.*);

    localparam logic [63:0] RQ_READ  = 64'h0012_0000_0100_0680;
    localparam logic [63:0] RQ_WRITE = 64'h0004_0001_0200_0921;
    localparam logic [63:0] RQ_NODAT = 64'h0000_0000_0007_0500;

    // Vector: setup, reqsel, in, out, clr, rsp_wr, rsp, ccpl_set |
    //         exp hs, exp pid, exp stage, exp valid, exp seq_err, exp ccpl
    function automatic logic [19:0] mk(bit s, bit [1:0] q, bit i, bit o, bit c,
            bit w, bit [1:0] r, bit p, bit [2:0] eh, bit ep, bit [2:0] es,
            bit ev, bit ee, bit ec);
        return {s, q, i, o, c, w, r, p, eh, ep, es, ev, ee, ec};
    endfunction

    localparam int NV = 28;
    localparam logic [19:0] VEC [NV] = '{
        // control read
        mk(1,0,0,0,0,0,0,0, 1,0,1,1,0,0),
        mk(0,0,1,0,0,0,0,0, 2,1,2,1,0,0),
        mk(0,0,0,0,1,0,0,0, 0,0,2,0,0,0),
        mk(0,0,0,0,0,1,2,0, 0,0,2,0,0,0),
        mk(0,0,1,0,0,0,0,0, 4,1,2,0,0,0),
        mk(0,0,1,0,0,0,0,0, 4,0,2,0,0,0),
        mk(0,0,0,1,0,0,0,0, 2,1,5,0,0,0),
        mk(0,0,0,0,0,0,0,1, 0,0,5,0,0,1),
        mk(0,0,0,1,0,0,0,0, 1,1,0,0,0,1),
        // control write
        mk(1,1,0,0,0,0,0,0, 1,0,1,1,0,0),
        mk(0,0,0,0,0,1,2,0, 0,0,1,1,0,0),
        mk(0,0,0,0,0,0,0,1, 0,0,1,1,0,0),
        mk(0,0,0,1,0,0,0,0, 2,1,3,1,0,0),
        mk(0,0,0,0,1,0,0,0, 0,0,3,0,0,0),
        mk(0,0,0,0,0,1,2,0, 0,0,3,0,0,0),
        mk(0,0,0,1,0,0,0,0, 1,1,3,0,0,0),
        mk(0,0,1,0,0,0,0,0, 2,1,4,0,0,0),
        mk(0,0,0,0,0,0,0,1, 0,0,4,0,0,1),
        mk(0,0,1,0,0,0,0,0, 5,1,0,0,0,1),
        // no-data with a sequence error, then a clean one
        mk(1,2,0,0,0,0,0,0, 1,0,1,1,0,0),
        mk(0,0,0,1,0,0,0,0, 3,1,6,1,1,0),
        mk(0,0,1,0,0,0,0,0, 3,1,6,1,0,0),
        mk(1,2,0,0,0,0,0,0, 1,0,1,1,0,0),
        mk(0,0,0,0,1,0,0,0, 0,0,1,0,0,0),
        mk(0,0,1,0,0,0,0,0, 2,1,4,0,0,0),
        mk(0,0,0,0,0,0,0,1, 0,0,4,0,0,1),
        mk(0,0,1,0,0,0,0,0, 5,1,0,0,0,1),
        mk(0,0,1,0,0,0,0,0, 2,1,0,0,0,1)
    };

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] req_img(logic [1:0] q);
        return (q == 2'd0) ? RQ_READ : (q == 2'd1) ? RQ_WRITE : RQ_NODAT;
    endfunction

    // Drive one cycle of inputs at the falling edge, then sample after the edge.
    task automatic step(bit s, logic [1:0] q, bit i, bit o, bit c, bit w,
                        logic [1:0] r, bit p);
        setup_pkt_i = s; setup_bytes_i = req_img(q); in_tok_i = i; out_tok_i = o;
        sw_clr_valid_i = c; sw_rsp_wr_i = w; sw_rsp_i = r; sw_ccpl_set_i = p;
        @(negedge clk);
        setup_pkt_i = 0; in_tok_i = 0; out_tok_i = 0;
        sw_clr_valid_i = 0; sw_rsp_wr_i = 0; sw_ccpl_set_i = 0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R2, R6, R8)
        check("R2 reset valid", int'(req_valid_o), 0);
        check("R6 reset stage", int'(stage_o), 0);
        check("R8 reset rsp", int'(rsp_o), 0);
        check("R8 reset hs", int'(hs_o), 0);
        check("R10 reset ccpl", int'(ccpl_o), 0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            logic [19:0] v;
            v = VEC[k];
            step(v[19], v[18:17], v[16], v[15], v[14], v[13], v[12:11], v[10]);
            check($sformatf("R8 hs step %0d", k), int'(hs_o), int'(v[9:7]));
            if (v[9:7] != 3'd0)
                check($sformatf("R9 pid step %0d", k), int'(pid_o), int'(v[6]));
            check($sformatf("R6 stage step %0d", k), int'(stage_o), int'(v[5:3]));
            check($sformatf("R2 valid step %0d", k), int'(req_valid_o), int'(v[2]));
            check($sformatf("R7 seq_err step %0d", k), int'(seq_err_o), int'(v[1]));
            check($sformatf("R10 ccpl step %0d", k), int'(ccpl_o), int'(v[0]));
        end

        // R3 and R5: field capture and classification
        step(1, 0, 0, 0, 0, 0, 0, 0);
        check("R12 irq after setup", int'(stage_irq_o), 1);
        check("R1 setup ack", int'(hs_o), 1);
        check("R3 req", int'(req_o), 16'h0680);
        check("R3 value", int'(value_o), 16'h0100);
        check("R3 index", int'(index_o), 16'h0000);
        check("R3 length", int'(length_o), 16'h0012);
        check("R5 read type", int'(xfer_type_o), 1);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        check("R12 irq one cycle", int'(stage_irq_o), 0);
        step(0, 0, 0, 0, 1, 1, 2, 0);
        check("R4 BUF blocked same cycle as clear", int'(rsp_o), 0);
        step(0, 0, 0, 0, 0, 1, 2, 0);
        check("R8 BUF accepted", int'(rsp_o), 2);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        check("R8 data sent", int'(hs_o), 4);
        check("R12 irq on DATA_IN", int'(stage_irq_o), 1);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        check("R12 no irq same stage", int'(stage_irq_o), 0);

        // R11: preempt mid-data with a write request
        step(1, 1, 0, 0, 0, 0, 0, 0);
        check("R11 stage", int'(stage_o), 1);
        check("R11 valid", int'(req_valid_o), 1);
        check("R11 rsp NAK", int'(rsp_o), 0);
        check("R11 length", int'(length_o), 16'h0004);
        check("R3 write index", int'(index_o), 16'h0001);
        check("R5 write type", int'(xfer_type_o), 2);
        step(0, 0, 0, 1, 0, 0, 0, 0);
        check("R11 new data NAK", int'(hs_o), 2);
        check("R9 new request DATA1", int'(pid_o), 1);

        // R11: STALL set by software is cleared by SETUP; R1 ack under STALL
        step(0, 0, 0, 0, 0, 1, 1, 0);
        check("R8 STALL written", int'(rsp_o), 1);
        step(0, 0, 0, 1, 0, 0, 0, 0);
        check("R8 STALL reply", int'(hs_o), 3);
        step(1, 2, 0, 0, 0, 0, 0, 0);
        check("R1 ack under STALL", int'(hs_o), 1);
        check("R11 STALL cleared", int'(rsp_o), 0);
        check("R5 no-data type", int'(xfer_type_o), 0);

        // R7: IN status then OUT in STATUS_IN is an error
        step(0, 0, 1, 0, 0, 0, 0, 0);
        check("R6 no-data to STATUS_IN", int'(stage_o), 4);
        step(0, 0, 0, 1, 0, 0, 0, 0);
        check("R7 status mismatch halt", int'(stage_o), 6);
        check("R7 rsp STALL", int'(rsp_o), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule